// File: doc/BRIEF.md
# Accumulator Subtract and Nibble-Swap Execute Unit

This block is the arithmetic slice of a small accumulator-style processor core. On every cycle in which its enable is high it takes an operation code, the accumulator value, a byte read from data memory and an immediate byte. It then registers an 8-bit result together with a destination select that tells the surrounding core whether the byte goes back to the accumulator or to the addressed memory location. Four status flags are kept inside the block: overflow, zero, half-carry and carry. They are updated only by subtraction and hold their value otherwise.

Subtraction always takes the operand away from the accumulator, never the other way round. Carry and half-carry are written as "no borrow" indicators. The two nibble-swap forms exchange the upper and lower halves of the memory byte, either in place or into the accumulator, and touch no flag. The datapath width and the subtractor structure (bit-serial borrow chain or a single wide subtract) are parameters.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted, and directly after it, `res_q` is 0, `dst_mem_q` is 0, `wr_q` is 0 and all four flags are 0.
- R2: Operation code 1 with `en`=1 produces `res_q` = `acc_in` − `imm_in` (mod 256), `dst_mem_q`=0 and `wr_q`=1 in the following cycle.
- R3: Operation code 2 with `en`=1 produces `res_q` = `acc_in` − `mem_in` (mod 256), `dst_mem_q`=0 and `wr_q`=1.
- R4: Operation code 3 with `en`=1 produces `res_q` = `acc_in` − `mem_in` (mod 256), `dst_mem_q`=1 (memory) and `wr_q`=1.
- R5: After any subtract, `c_q` is 1 when the accumulator is not below the operand as an unsigned number, and 0 otherwise.
- R6: After any subtract, `ac_q` is 1 when the accumulator's bits 3:0 are not below the operand's bits 3:0, and 0 otherwise.
- R7: After any subtract, `ov_q` is 1 exactly when accumulator and operand differ in bit 7 and the difference's bit 7 differs from the accumulator's bit 7.
- R8: After any subtract, `z_q` is 1 exactly when the 8-bit difference is zero.
- R9: Operation code 4 with `en`=1 produces `res_q` = {`mem_in`[3:0], `mem_in`[7:4]}, `dst_mem_q`=1, `wr_q`=1, and leaves all four flags unchanged.
- R10: Operation code 5 with `en`=1 produces `res_q` = {`mem_in`[3:0], `mem_in`[7:4]}, `dst_mem_q`=0, `wr_q`=1, and leaves all four flags unchanged.
- R11: With `en`=0 the next cycle shows `wr_q`=0 and unchanged `res_q`, `dst_mem_q` and flags, whatever the operation code and data.
- R12: Operation codes 0, 6 and 7 with `en`=1 give `wr_q`=0 and leave `res_q`, `dst_mem_q` and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Execute enable for this cycle |
| op | input | 3 | Operation code (0 idle, 1 sub imm to acc, 2 sub mem to acc, 3 sub mem to mem, 4 swap in memory, 5 swap to acc, 6/7 idle) |
| acc_in | input | 8 | Current accumulator value |
| mem_in | input | 8 | Byte read from the addressed data memory location |
| imm_in | input | 8 | Immediate byte from the instruction |
| res_q | output | 8 | Registered result byte |
| dst_mem_q | output | 1 | Result destination: 1 memory, 0 accumulator |
| wr_q | output | 1 | Result is to be written this cycle |
| ov_q | output | 1 | Signed overflow flag |
| z_q | output | 1 | Zero flag |
| ac_q | output | 1 | Half-carry (no borrow from bit 3) flag |
| c_q | output | 1 | Carry (no borrow) flag |

## Verification
Every result, the destination select, the write strobe and the flags are due one clock after the edge at which `en` and the operands are presented, because a single register stage lies between the inputs and the outputs. The bench changes inputs on the falling edge, lets one rising edge pass and samples a nanosecond later, so each operation is checked in the cycle it lands. Flag retention across swaps, idle codes and disabled cycles is checked against the flag values the bench predicted for the preceding operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_IDLE    = 3'd0,
      OP_SUB_IMM = 3'd1,
      OP_SUB_M2A = 3'd2,
      OP_SUB_M2M = 3'd3,
      OP_SWP_M2M = 3'd4,
      OP_SWP_M2A = 3'd5
   } alu_op_e;

   typedef struct packed {
      logic ov;
      logic z;
      logic ac;
      logic c;
   } alu_flags_t;

endpackage

// File: rtl/acc_alu_ctl.sv
module acc_alu_ctl
   import acc_alu_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output logic            is_sub,
   output logic            use_imm,
   output logic            is_swap,
   output logic            to_mem,
   output logic            writes
);

   always_comb begin
      is_sub  = 1'b0;
      use_imm = 1'b0;
      is_swap = 1'b0;
      to_mem  = 1'b0;
      writes  = 1'b0;
      case (op)
         OP_SUB_IMM: begin
            is_sub  = 1'b1;
            use_imm = 1'b1;
            writes  = 1'b1;
         end
         OP_SUB_M2A: begin
            is_sub  = 1'b1;
            writes  = 1'b1;
         end
         OP_SUB_M2M: begin
            is_sub  = 1'b1;
            to_mem  = 1'b1;
            writes  = 1'b1;
         end
         OP_SWP_M2M: begin
            is_swap = 1'b1;
            to_mem  = 1'b1;
            writes  = 1'b1;
         end
         OP_SWP_M2A: begin
            is_swap = 1'b1;
            writes  = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_alu_sub.sv
module acc_alu_sub
   import acc_alu_pkg::*;
#(
   parameter int W     = 8,
   parameter int STYLE = 0
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] diff,
   output alu_flags_t   flg
);

   localparam int HALF = W / 2;

   logic no_borrow_half;
   logic no_borrow_full;

   generate
      if (STYLE == 0) begin : g_ripple
         logic [W:0] bw;
         assign bw[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign diff[i]  = a[i] ^ b[i] ^ bw[i];
            assign bw[i+1]  = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & bw[i]);
         end
         assign no_borrow_half = ~bw[HALF];
         assign no_borrow_full = ~bw[W];
      end else begin : g_native
         logic [W:0]    wide;
         logic [HALF:0] low;
         assign wide           = {1'b0, a} - {1'b0, b};
         assign low            = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]};
         assign diff           = wide[W-1:0];
         assign no_borrow_full = ~wide[W];
         assign no_borrow_half = ~low[HALF];
      end
   endgenerate

   always_comb begin
      flg.ov = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
      flg.z  = ~|diff;
      flg.ac = no_borrow_half;
      flg.c  = no_borrow_full;
   end

endmodule

// File: rtl/acc_alu_swap.sv
module acc_alu_swap #(
   parameter int W = 8
)(
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   localparam int HALF = W / 2;

   generate
      for (genvar i = 0; i < HALF; i++) begin : g_half
         assign dout[i]        = din[i + HALF];
         assign dout[i + HALF] = din[i];
      end
   endgenerate

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SUB_STYLE = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] mem_in,
   input  logic [DATA_W-1:0] imm_in,
   output logic [DATA_W-1:0] res_q,
   output logic              dst_mem_q,
   output logic              wr_q,
   output logic              ov_q,
   output logic              z_q,
   output logic              ac_q,
   output logic              c_q
);

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("acc_alu: DATA_W must be even and at least 4");
      end
      if (SUB_STYLE != 0 && SUB_STYLE != 1) begin : g_bad_style
         $error("acc_alu: SUB_STYLE must be 0 (ripple) or 1 (native)");
      end
   endgenerate

   logic              is_sub, use_imm, is_swap, to_mem, writes;
   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] sub_diff;
   logic [DATA_W-1:0] swapped;
   logic [DATA_W-1:0] nxt_res;
   alu_flags_t        sub_flg;
   alu_flags_t        flags_q;

   acc_alu_ctl u_ctl (
      .op      (op),
      .is_sub  (is_sub),
      .use_imm (use_imm),
      .is_swap (is_swap),
      .to_mem  (to_mem),
      .writes  (writes)
   );

   assign operand = use_imm ? imm_in : mem_in;

   acc_alu_sub #(.W(DATA_W), .STYLE(SUB_STYLE)) u_sub (
      .a    (acc_in),
      .b    (operand),
      .diff (sub_diff),
      .flg  (sub_flg)
   );

   acc_alu_swap #(.W(DATA_W)) u_swap (
      .din  (mem_in),
      .dout (swapped)
   );

   always_comb begin
      if (is_sub)       nxt_res = sub_diff;
      else if (is_swap) nxt_res = swapped;
      else              nxt_res = res_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q     <= '0;
         dst_mem_q <= 1'b0;
         wr_q      <= 1'b0;
         flags_q   <= '0;
      end else begin
         wr_q <= en & writes;
         if (en & writes) begin
            res_q     <= nxt_res;
            dst_mem_q <= to_mem;
         end
         if (en & is_sub) begin
            flags_q <= sub_flg;
         end
      end
   end

   assign ov_q = flags_q.ov;
   assign z_q  = flags_q.z;
   assign ac_q = flags_q.ac;
   assign c_q  = flags_q.c;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [OP_W-1:0]   op,
   input logic [DATA_W-1:0] acc_in,
   input logic [DATA_W-1:0] mem_in,
   input logic [DATA_W-1:0] imm_in,
   input logic [DATA_W-1:0] res_q,
   input logic              dst_mem_q,
   input logic              wr_q,
   input logic              ov_q,
   input logic              z_q,
   input logic              ac_q,
   input logic              c_q
);

   logic              sub_op, swap_op, idle_op;
   logic [DATA_W-1:0] chk_opnd;
   logic [3:0]        flag_vec;

   assign sub_op   = (op == OP_SUB_IMM) || (op == OP_SUB_M2A) || (op == OP_SUB_M2M);
   assign swap_op  = (op == OP_SWP_M2M) || (op == OP_SWP_M2A);
   assign idle_op  = !sub_op && !swap_op;
   assign chk_opnd = (op == OP_SUB_IMM) ? imm_in : mem_in;
   assign flag_vec = {ov_q, z_q, ac_q, c_q};

   a_r11_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !wr_q && $stable(res_q) && $stable(dst_mem_q) && $stable(flag_vec));

   a_r12_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      en && idle_op |=> !wr_q && $stable(res_q) && $stable(flag_vec));

   a_r9_swap_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      en && swap_op |=> wr_q && $stable(flag_vec));

   a_r5_no_borrow_carry: assert property (@(posedge clk) disable iff (!rst_n)
      en && sub_op |=> c_q == ($past(acc_in) >= $past(chk_opnd)));

   a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      en && sub_op |=> z_q == (res_q == '0));

   a_r4_mem_dest: assert property (@(posedge clk) disable iff (!rst_n)
      en && (op == OP_SUB_M2M) |=> wr_q && dst_mem_q);

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .op        (op),
   .acc_in    (acc_in),
   .mem_in    (mem_in),
   .imm_in    (imm_in),
   .res_q     (res_q),
   .dst_mem_q (dst_mem_q),
   .wr_q      (wr_q),
   .ov_q      (ov_q),
   .z_q       (z_q),
   .ac_q      (ac_q),
   .c_q       (c_q)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [2:0] op = 3'd0;
   logic [7:0] acc_in = 8'd0, mem_in = 8'd0, imm_in = 8'd0;
   logic [7:0] res_q;
   logic       dst_mem_q, wr_q, ov_q, z_q, ac_q, c_q;

   int n_chk = 0;
   int n_err = 0;

   logic [7:0] e_res = 8'd0;
   logic       e_dst = 1'b0;
   logic       e_ov = 1'b0, e_z = 1'b0, e_ac = 1'b0, e_c = 1'b0;

   always #5 clk = ~clk;

   acc_alu u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .op(op),
      .acc_in(acc_in), .mem_in(mem_in), .imm_in(imm_in),
      .res_q(res_q), .dst_mem_q(dst_mem_q), .wr_q(wr_q),
      .ov_q(ov_q), .z_q(z_q), .ac_q(ac_q), .c_q(c_q)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_flags(input string tag);
      chk({tag, " ov"}, ov_q, e_ov);
      chk({tag, " z"},  z_q,  e_z);
      chk({tag, " ac"}, ac_q, e_ac);
      chk({tag, " c"},  c_q,  e_c);
   endtask

   // Drive one operation, predict, let one rising edge pass, then compare.
   task automatic run(input logic [2:0] o, input logic [7:0] a, input logic [7:0] m,
                      input logic [7:0] i, input logic e, input string tag);
      logic [7:0] b;
      int         sd;
      logic       e_wr;
      @(negedge clk);
      op = o; acc_in = a; mem_in = m; imm_in = i; en = e;
      b    = (o == 3'd1) ? i : m;
      e_wr = 1'b0;
      if (e && (o == 3'd1 || o == 3'd2 || o == 3'd3)) begin
         e_res = a - b;
         e_dst = (o == 3'd3);
         e_wr  = 1'b1;
         e_c   = (a >= b);
         e_ac  = (a[3:0] >= b[3:0]);
         sd    = $signed(a) - $signed(b);
         e_ov  = (sd > 127) || (sd < -128);
         e_z   = (a == b);
      end else if (e && (o == 3'd4 || o == 3'd5)) begin
         e_res = {m[3:0], m[7:4]};
         e_dst = (o == 3'd4);
         e_wr  = 1'b1;
      end
      @(posedge clk);
      #1;
      chk({tag, " res"}, res_q, e_res);
      chk({tag, " dst"}, dst_mem_q, e_dst);
      chk({tag, " wr"},  wr_q, e_wr);
      if (e && (o == 3'd1 || o == 3'd2 || o == 3'd3)) begin
         chk("R5 carry",     c_q,  e_c);
         chk("R6 halfcarry", ac_q, e_ac);
         chk("R7 overflow",  ov_q, e_ov);
         chk("R8 zero",      z_q,  e_z);
      end else begin
         check_flags({tag, " flags held"});
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 res", res_q, 0);
      chk("R1 dst", dst_mem_q, 0);
      chk("R1 wr",  wr_q, 0);
      check_flags("R1");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 res after release", res_q, 0);
      check_flags("R1 after release");

      // R2: every accumulator/immediate pair
      for (int a = 0; a < 256; a++)
         for (int i = 0; i < 256; i++)
            run(3'd1, a[7:0], 8'(a ^ 8'h5A), i[7:0], 1'b1, "R2");

      // R3 and R4: every accumulator against a spread of memory bytes
      for (int a = 0; a < 256; a++)
         for (int m = 0; m < 256; m += 5) begin
            run(3'd2, a[7:0], m[7:0], 8'(~m), 1'b1, "R3");
            run(3'd3, a[7:0], m[7:0], 8'(m + 1), 1'b1, "R4");
         end

      // Explicit corner values for the flags
      run(3'd1, 8'h80, 8'h00, 8'h01, 1'b1, "R7 corner 80-01");
      run(3'd2, 8'h7F, 8'hFF, 8'h00, 1'b1, "R7 corner 7F-FF");
      run(3'd3, 8'h10, 8'h01, 8'h00, 1'b1, "R6 corner 10-01");
      run(3'd1, 8'h42, 8'h00, 8'h42, 1'b1, "R8 corner equal");

      // R9 and R10: every memory byte, flags set up by a preceding subtract
      for (int m = 0; m < 256; m++) begin
         run(3'd1, 8'(m), 8'h00, 8'(m * 3), 1'b1, "R2 setup");
         run(3'd4, 8'(m + 7), m[7:0], 8'h33, 1'b1, "R9");
         run(3'd5, 8'(m + 9), m[7:0], 8'h44, 1'b1, "R10");
      end

      // R11: enable low with every operation code
      run(3'd2, 8'h05, 8'h09, 8'h00, 1'b1, "R3 setup");
      for (int o = 0; o < 8; o++)
         run(o[2:0], 8'hC3, 8'h3C, 8'hA5, 1'b0, "R11");

      // R12: idle codes with enable high
      run(3'd4, 8'h00, 8'h96, 8'h00, 1'b1, "R9 setup");
      run(3'd0, 8'h11, 8'h22, 8'h33, 1'b1, "R12 code0");
      run(3'd6, 8'h44, 8'h55, 8'h66, 1'b1, "R12 code6");
      run(3'd7, 8'h77, 8'h88, 8'h99, 1'b1, "R12 code7");

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule